// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a clocked host and an external 32K x 8 asynchronous static RAM. The RAM has a 15-bit address, an 8-bit shared data bus and three active-low strobes: chip select, output enable and write enable. The host offers one single-word request at a time over a valid/ready handshake. The block registers the address and the write data, then plays out a strobe sequence in which every phase lasts a whole number of clock cycles. Those counts are fixed at elaboration from the speed grade (70, 85 or 100 ns) and the clock period. Each time window becomes ceil(time / period) cycles, with a floor of one cycle.

A read lowers chip select and output enable together, with write enable high. The strobes stay low until the cycle time, the address access time and the output-enable access time have all passed. The bus is sampled on the last of those cycles. The byte is returned with a one-cycle valid pulse, and a guard period then lets the RAM release the bus. A write holds output enable high and lowers chip select and write enable together. The block drives the data bus only while write enable is low. Both strobes rise together once the pulse, select-to-end, address-to-end and data-setup windows are met. Idle cycles are then added if needed so that the full write cycle time is reached. The bus is split into an input, an output and an output-enable. The pad tristate lives outside this block.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: After reset, chip select, output enable and write enable are high, the data-bus enable is low, ready is high and the response valid is low.
- R2: A read holds chip select and output enable low and write enable high for R_ACT = max(ceil(cycle/period), ceil(oe_access/period)) consecutive cycles. This is 14 cycles at 70 ns grade and 5 ns clock. The RAM address equals the address captured at acceptance.
- R3: Read data is the bus value seen on the final strobe-low cycle. It is presented with the response valid high for exactly one cycle, in the cycle after the strobes rise.
- R4: A write holds chip select and write enable low and output enable high for W_LOW = max of ceil(60/period), ceil(select_to_end/period) and ceil(40/period) cycles. This is 13 cycles at the default parameters. The data-bus enable is high exactly when write enable is low.
- R5: The RAM address and the driven write data stay constant while chip select is low, even if the host request inputs change after acceptance. The RAM stores the accepted byte.
- R6: Ready is low from the cycle after acceptance until the operation ends. That is R_ACT + HZ cycles for a read (19 by default) and max(ceil(cycle/period), W_LOW) cycles for a write (14 by default). Requests offered while ready is low are not taken.
- R7: The data-bus enable never rises until output enable has been high for at least HZ = ceil(output-to-high-Z/period) cycles, which is 5 by default. The bus is never driven while output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request offered |
| req_ready | output | 1 | Controller idle, request taken when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read data valid, one-cycle pulse |
| rsp_rdata | output | 8 | Read byte |
| sram_addr | output | 15 | RAM address |
| sram_cs_n | output | 1 | RAM chip select, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_dq_out | output | 8 | Byte driven onto the RAM bus |
| sram_dq_oe | output | 1 | Enable for driving the RAM bus |
| sram_dq_in | input | 8 | Byte read from the RAM bus |

## Verification
A wrong cycle count shows at the ports within one operation. A strobe window that is one cycle short lets the RAM model return filler instead of stored data, so the read byte is wrong. The ready-low length also shifts at the next handshake. A sequencer stuck in a bad state leaves ready low and trips the watchdog. A bus-direction fault shows as contention with output enable low, or as a missing byte when the stored location is read back later.

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl #(
  parameter int GRADE_NS = 70,
  parameter int CLK_PS   = 5000,
  parameter int ADDR_W   = 15,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_cs_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);

  function automatic int cyc(input int ns);
    int c;
    c = (ns * 1000 + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int T_CYC = (GRADE_NS == 100) ? 100 : (GRADE_NS == 85) ? 85 : 70;
  localparam int T_OE  = (GRADE_NS == 100) ? 50  : (GRADE_NS == 85) ? 45 : 40;
  localparam int T_SEL = (GRADE_NS == 100) ? 80  : (GRADE_NS == 85) ? 75 : 65;
  localparam int T_HZ  = (GRADE_NS == 100) ? 35  : (GRADE_NS == 85) ? 30 : 25;
  localparam int T_WP  = 60;
  localparam int T_DS  = 40;

  localparam int R_ACT  = imax(cyc(T_CYC), cyc(T_OE));
  localparam int W_LOW  = imax(imax(cyc(T_WP), cyc(T_SEL)), cyc(T_DS));
  localparam int W_TOT  = imax(cyc(T_CYC), W_LOW);
  localparam int W_TAIL = W_TOT - W_LOW;
  localparam int HZ     = cyc(T_HZ);
  localparam int MAXC   = imax(imax(R_ACT, W_TOT), HZ);
  localparam int CNT_W  = $clog2(MAXC + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_GUARD} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              rvalid_q, cs_n_q, oe_n_q, we_n_q;

  assign req_ready   = (st == ST_IDLE);
  assign rsp_valid   = rvalid_q;
  assign rsp_rdata   = rdata_q;
  assign sram_addr   = addr_q;
  assign sram_cs_n   = cs_n_q;
  assign sram_oe_n   = oe_n_q;
  assign sram_we_n   = we_n_q;
  assign sram_dq_out = wdata_q;
  assign sram_dq_oe  = ~we_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      cs_n_q   <= 1'b1;
      oe_n_q   <= 1'b1;
      we_n_q   <= 1'b1;
    end else begin
      rvalid_q <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          cs_n_q  <= 1'b0;
          oe_n_q  <= req_write;
          we_n_q  <= ~req_write;
          st      <= req_write ? ST_WRITE : ST_READ;
          cnt     <= req_write ? CNT_W'(W_LOW - 1) : CNT_W'(R_ACT - 1);
        end
        ST_READ: if (cnt == '0) begin
          rdata_q  <= sram_dq_in;
          rvalid_q <= 1'b1;
          cs_n_q   <= 1'b1;
          oe_n_q   <= 1'b1;
          st       <= ST_GUARD;
          cnt      <= CNT_W'(HZ - 1);
        end else cnt <= cnt - 1'b1;
        ST_WRITE: if (cnt == '0) begin
          cs_n_q <= 1'b1;
          we_n_q <= 1'b1;
          if (W_TAIL > 0) begin
            st  <= ST_GUARD;
            cnt <= CNT_W'((W_TAIL > 0) ? W_TAIL - 1 : 0);
          end else st <= ST_IDLE;
        end else cnt <= cnt - 1'b1;
        default: if (cnt == '0) st <= ST_IDLE;
                 else cnt <= cnt - 1'b1;
      endcase
    end
  end

  logic [CNT_W-1:0] we_run, rd_run, oe_hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_run    <= '0;
      rd_run    <= '0;
      oe_hi_run <= CNT_W'(HZ);
    end else begin
      we_run    <= sram_we_n ? '0 : we_run + 1'b1;
      rd_run    <= sram_oe_n ? '0 : rd_run + 1'b1;
      oe_hi_run <= !sram_oe_n ? '0 :
                   (oe_hi_run >= CNT_W'(HZ)) ? oe_hi_run : oe_hi_run + 1'b1;
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> sram_cs_n && sram_oe_n && sram_we_n && !sram_dq_oe);
  // R2
  rd_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_oe_n) |-> rd_run == CNT_W'(R_ACT));
  // R3
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R4
  we_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> !sram_cs_n && sram_oe_n);
  // R4
  we_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> we_run == CNT_W'(W_LOW));
  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_cs_n && $past(!sram_cs_n) |-> $stable(sram_addr) && $stable(sram_dq_out));
  // R6
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_cs_n |-> !req_ready);
  // R7
  turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe) |-> oe_hi_run >= CNT_W'(HZ));
  // R7
  no_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n);

endmodule

// File: tb/sram_cycle_ctrl_tb.sv
module sram_cycle_ctrl_tb;
  localparam int CLK_NS = 5;
  localparam int R_ACT  = (70 + CLK_NS - 1) / CLK_NS;
  localparam int HZ     = (25 + CLK_NS - 1) / CLK_NS;
  localparam int W_LOW  = (65 + CLK_NS - 1) / CLK_NS;
  localparam int W_TOT  = (70 + CLK_NS - 1) / CLK_NS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, sram_cs_n, sram_oe_n, sram_we_n, sram_dq_oe;
  logic [7:0] rsp_rdata, sram_dq_out, sram_dq_in;
  logic [14:0] sram_addr;

  int checks = 0, fails = 0, cycles = 0;
  logic [7:0] mem [512];
  int rd_low = 0, we_low = 0, oe_hi = 100;
  logic [14:0] cur_addr = '0;

  sram_cycle_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
    .sram_cs_n(sram_cs_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
    .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in));

  always #2.5 clk = ~clk;

  assign sram_dq_in = (!sram_cs_n && !sram_oe_n && sram_we_n && rd_low >= R_ACT)
                      ? mem[sram_addr[8:0]] : 8'h5A;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (!sram_cs_n && !sram_we_n && sram_dq_oe) mem[sram_addr[8:0]] <= sram_dq_out;
      if (sram_dq_oe && !sram_oe_n) check(0, "R7 bus driven with oe low", 1, 0);
      if (sram_dq_oe == sram_we_n) check(0, "R4 bus enable vs we", int'(sram_dq_oe), int'(!sram_we_n));
      if (!sram_cs_n) check(sram_addr == cur_addr, "R5 address held", sram_addr, cur_addr);
      if (sram_dq_oe && oe_hi == 0) check(0, "R7 turnaround", oe_hi, HZ);
      if (!sram_we_n && we_low == 0) check(oe_hi > HZ, "R7 turnaround cycles", oe_hi, HZ + 1);
      if (sram_we_n && we_low > 0) check(we_low == W_LOW, "R4 write strobe length", we_low, W_LOW);
      if (sram_oe_n && rd_low > 0) check(rd_low == R_ACT, "R2 read strobe length", rd_low, R_ACT);
      if (!sram_oe_n) check(!sram_cs_n && sram_we_n, "R2 read strobes", sram_cs_n, 0);
    end
    we_low = sram_we_n ? 0 : we_low + 1;
    rd_low = sram_oe_n ? 0 : rd_low + 1;
    oe_hi  = sram_oe_n ? oe_hi + 1 : 0;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic do_op(input bit w, input logic [14:0] a, input logic [7:0] d);
    int busy = 0, pulses = 0;
    logic [7:0] got = '0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; cur_addr = a;
    @(negedge clk);
    req_addr = ~a; req_wdata = ~d; req_write = ~w;
    while (!req_ready) begin
      busy++;
      if (rsp_valid) begin pulses++; got = rsp_rdata; end
      @(negedge clk);
    end
    req_valid = 1'b0;
    if (rsp_valid) pulses++;
    check(busy == (w ? W_TOT : R_ACT + HZ), "R6 busy length", busy, w ? W_TOT : R_ACT + HZ);
    if (!w) begin
      check(pulses == 1, "R3 one valid pulse", pulses, 1);
      check(got == d, "R3 read data", got, d);
    end else check(pulses == 0, "R3 no pulse on write", pulses, 0);
  endtask

  function automatic logic [14:0] addr_of(input int i);
    return (i < 256) ? {6'(i * 5), 9'(i)} : 15'h7FFF;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check(sram_cs_n && sram_oe_n && sram_we_n && !sram_dq_oe && !rsp_valid,
          "R1 reset strobes", {sram_cs_n, sram_oe_n, sram_we_n}, 7);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !rsp_valid, "R1 ready after reset", req_ready, 1);
    for (int i = 0; i < 257; i++) do_op(1'b1, addr_of(i), 8'(i * 37 + 11));
    for (int i = 0; i < 257; i++) do_op(1'b0, addr_of(i), 8'(i * 37 + 11));
    for (int i = 0; i < 257; i += 3) begin
      do_op(1'b1, addr_of(i), 8'(i * 91 + 3));
      do_op(1'b0, addr_of(i), 8'(i * 91 + 3));
      do_op(1'b0, addr_of(256 - i), 8'(((i % 3 == 2) ? (256 - i) * 91 + 3
                 : (256 - i) * 37 + 11)));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule